// File: doc/BRIEF.md
# Cache-Block Operation Permission Gate

This block sits beside the execute stage of a core and decides whether a cache-block operation may go ahead. Three operation classes are handled: block zeroing, clean or flush, and invalidate. The decision depends on the current privilege level, the virtualization flag, and three per-level enable vectors. The machine, hypervisor and supervisor environment-configuration levels each supply one of these vectors, with one enable bit per operation class.

Once the configuration checks pass, the gate also uses the result of a memory permission probe made outside this block. Zeroing needs store permission. Clean, flush and invalidate need load permission, or store permission when load permission is missing. The gate aligns the request address down to the cache-block boundary and reports which probe kind applies. It then gives an allow flag and an exception cause. The decision is combinational within one cycle. A registered copy of the decision (valid, allow, cause) is presented one clock later.

Top module: `cbo_gate`

## Requirements
- R1: When privilege (U=0, S=1, M=3) is below M and the machine-level enable bit of the operation is clear, allow is 0 and cause is 2 (illegal instruction).
- R2: When the machine check passes and virt is 1, cause is 22 (virtual instruction) with allow 0 if either condition holds: privilege is U or S and the hypervisor-level bit is clear, or privilege is U and the supervisor-level bit is clear.
- R3: When the machine check passes, virt is 0, privilege is U and the supervisor-level bit is clear, cause is 2 with allow 0.
- R4: The checks take priority in a fixed order: the machine check first, then the virtualized check, then the supervisor check.
- R5: At privilege M no configuration check can fail, so cause is never 2 or 22.
- R6: The operation code req_op (0 zero, 1 clean, 2 flush, 3 invalidate) selects the enable bit: bit 0 for zero, bit 1 for both clean and flush, and bit 2 for invalidate. The same bit position is used in all three vectors.
- R7: blk_addr equals req_addr with its low log2(BLK_BYTES) bits cleared.
- R8: Zero always reports probe kind 2 (store) after the configuration checks pass. It is allowed only if store_ok is 1. Otherwise cause is 15, or 23 when virt is 1.
- R9: Clean, flush and invalidate report probe kind 1 (load) when load_ok is 1, and probe kind 2 (store) otherwise. They are allowed if load_ok or store_ok is 1. Otherwise cause is 15, or 23 when virt is 1.
- R10: When a configuration check fails, probe kind is 0 (none). Whenever allow is 1, cause is 0.
- R11: res_valid follows req_valid one clock later, and res_valid is 0 during reset. While res_valid is 1, res_allow and res_cause hold the allow and cause of the previous cycle. While res_valid is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| priv | input | 2 | Privilege: 0 U, 1 S, 3 M |
| virt | input | 1 | Virtualization active |
| m_en | input | 3 | Machine-level enables {inval, clean/flush, zero} |
| h_en | input | 3 | Hypervisor-level enables, same layout |
| s_en | input | 3 | Supervisor-level enables, same layout |
| req_addr | input | ADDR_W | Target address |
| load_ok | input | 1 | Load probe over the block succeeded |
| store_ok | input | 1 | Store probe over the block succeeded |
| allow | output | 1 | Operation may proceed |
| cause | output | 5 | Exception cause, 0 when allowed |
| blk_addr | output | ADDR_W | Block-aligned address |
| probe_kind | output | 2 | 0 none, 1 load, 2 store |
| res_valid | output | 1 | Registered request valid |
| res_allow | output | 1 | Registered allow |
| res_cause | output | 5 | Registered cause |

## Verification
Directed cases come first. Each one sets up a single failing level while the others are enabled, which separates the machine, virtualized and supervisor checks. Overlapping failures then show whether the machine check wins over the virtualized one. Flush and clean are run with only bit 1 set, which shows whether the operation-to-bit mapping is right. The probe combinations (load only, store only, neither, with and without virt) tell the load path, the store fallback and the two store-fault causes apart. A long stream of random privilege, enable, probe and address patterns is then compared every cycle against a behavioural model, covering both the combinational and the registered outputs.

// File: rtl/cbo_gate.sv
module cbo_gate #(
  parameter int ADDR_W    = 64,
  parameter int BLK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [2:0]        m_en,
  input  logic [2:0]        h_en,
  input  logic [2:0]        s_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              load_ok,
  input  logic              store_ok,
  output logic              allow,
  output logic [4:0]        cause,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [1:0]        probe_kind,
  output logic              res_valid,
  output logic              res_allow,
  output logic [4:0]        res_cause
);

  localparam int          OFF_W    = $clog2(BLK_BYTES);
  localparam logic [1:0]  PRIV_S   = 2'd1;
  localparam logic [1:0]  PRIV_M   = 2'd3;
  localparam logic [4:0]  C_ILL    = 5'd2;
  localparam logic [4:0]  C_VIRT   = 5'd22;
  localparam logic [4:0]  C_ST     = 5'd15;
  localparam logic [4:0]  C_ST_G   = 5'd23;
  localparam logic [1:0]  PK_NONE  = 2'd0;
  localparam logic [1:0]  PK_LOAD  = 2'd1;
  localparam logic [1:0]  PK_STORE = 2'd2;

  logic [1:0] op_idx;
  logic       m_bit, h_bit, s_bit;
  logic       m_fail, v_fail, s_fail, cfg_bad;
  logic [4:0] cfg_cause;
  logic       is_zero, mem_ok;

  assign op_idx = (req_op == 2'd0) ? 2'd0 : (req_op == 2'd3) ? 2'd2 : 2'd1;
  assign m_bit  = m_en[op_idx];
  assign h_bit  = h_en[op_idx];
  assign s_bit  = s_en[op_idx];

  assign m_fail = (priv < PRIV_M) && !m_bit;
  assign v_fail = virt && (((priv <= PRIV_S) && !h_bit) || ((priv < PRIV_S) && !s_bit));
  assign s_fail = (priv < PRIV_S) && !s_bit;

  assign cfg_bad   = m_fail || v_fail || s_fail;
  assign cfg_cause = m_fail ? C_ILL : v_fail ? C_VIRT : C_ILL;

  assign is_zero = (req_op == 2'd0);
  assign mem_ok  = is_zero ? store_ok : (load_ok || store_ok);

  assign blk_addr = req_addr & ~ADDR_W'(BLK_BYTES - 1);

  always_comb begin
    if (cfg_bad)                  probe_kind = PK_NONE;
    else if (is_zero || !load_ok) probe_kind = PK_STORE;
    else                          probe_kind = PK_LOAD;
  end

  assign allow = !cfg_bad && mem_ok;
  assign cause = cfg_bad ? cfg_cause : mem_ok ? 5'd0 : (virt ? C_ST_G : C_ST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_cause <= 5'd0;
    end else begin
      res_valid <= req_valid;
      res_allow <= req_valid && allow;
      res_cause <= req_valid ? cause : 5'd0;
    end
  end

  assert_mlevel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (priv != PRIV_M && !m_en[op_idx]) |-> (!allow && cause == C_ILL));

  assert_mmode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_M) |-> (cause != C_ILL && cause != C_VIRT));

  assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_addr[OFF_W-1:0] == '0) && (blk_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]));

  assert_zero_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && req_op == 2'd0) |-> (probe_kind == PK_STORE && store_ok));

  assert_mgmt_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && req_op != 2'd0) |-> (load_ok || store_ok));

  assert_allow_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    allow |-> (cause == 5'd0 && probe_kind != PK_NONE));

  assert_reg_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_allow == $past(allow) && res_cause == $past(cause)));

endmodule

// File: tb/sim_cbo_gate.sv
module sim_cbo_gate;
  localparam int AW = 64;
  localparam int BB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0, priv = 2'd0;
  logic virt = 1'b0;
  logic [2:0] m_en = 3'd0, h_en = 3'd0, s_en = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic load_ok = 1'b0, store_ok = 1'b0;
  logic allow, res_valid, res_allow;
  logic [4:0] cause, res_cause;
  logic [AW-1:0] blk_addr;
  logic [1:0] probe_kind;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cbo_gate #(.ADDR_W(AW), .BLK_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .priv(priv), .virt(virt), .m_en(m_en), .h_en(h_en), .s_en(s_en),
    .req_addr(req_addr), .load_ok(load_ok), .store_ok(store_ok),
    .allow(allow), .cause(cause), .blk_addr(blk_addr), .probe_kind(probe_kind),
    .res_valid(res_valid), .res_allow(res_allow), .res_cause(res_cause));

  int   exp_allow, exp_cause, exp_pk;
  string exp_tag;
  bit   q_valid[$];
  int   q_allow[$];
  int   q_cause[$];

  task automatic check(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int bitpos;
    bit me, he, se, fail_v;
    bitpos = (req_op == 0) ? 0 : (req_op == 3) ? 2 : 1;
    me = m_en[bitpos]; he = h_en[bitpos]; se = s_en[bitpos];
    exp_allow = 0; exp_pk = 0;
    fail_v = virt && ((priv <= 1 && !he) || (priv == 0 && !se));
    if (priv != 3 && !me) begin
      exp_cause = 2; exp_tag = "R1";
    end else if (fail_v) begin
      exp_cause = 22; exp_tag = "R2";
    end else if (priv == 0 && !se) begin
      exp_cause = 2; exp_tag = "R3";
    end else if (req_op == 0) begin
      exp_tag = "R8"; exp_pk = 2;
      if (store_ok) begin exp_allow = 1; exp_cause = 0; end
      else exp_cause = virt ? 23 : 15;
    end else begin
      exp_tag = "R9";
      exp_pk = load_ok ? 1 : 2;
      if (load_ok || store_ok) begin exp_allow = 1; exp_cause = 0; end
      else exp_cause = virt ? 23 : 15;
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [1:0] pr, bit vi,
                      logic [2:0] me, logic [2:0] he, logic [2:0] se,
                      logic [AW-1:0] a, bit lo, bit so, string tag);
    string t;
    @(negedge clk);
    if (q_valid.size() > 0) begin
      bit pv; int pa, pc;
      pv = q_valid.pop_front(); pa = q_allow.pop_front(); pc = q_cause.pop_front();
      check("R11", "res_valid", res_valid, pv);
      check("R11", "res_allow", res_allow, pv ? pa : 0);
      check("R11", "res_cause", res_cause, pv ? pc : 0);
    end
    req_valid = v; req_op = op; priv = pr; virt = vi;
    m_en = me; h_en = he; s_en = se; req_addr = a; load_ok = lo; store_ok = so;
    #1;
    model();
    t = (tag == "") ? exp_tag : tag;
    check(t, "allow", allow, exp_allow);
    check(t, "cause", cause, exp_cause);
    check((exp_pk == 0) ? "R10" : t, "probe_kind", probe_kind, exp_pk);
    check("R7", "blk_addr", blk_addr, req_addr & ~64'(BB - 1));
    q_valid.push_back(v); q_allow.push_back(exp_allow); q_cause.push_back(exp_cause);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "res_valid in reset", res_valid, 0);
    check("R11", "res_cause in reset", res_cause, 0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 0, 0, 3'b110, 3'b111, 3'b111, 64'h1234, 1, 1, "R1");
    step(1, 3, 1, 1, 3'b011, 3'b111, 3'b111, 64'h0, 1, 1, "R1");
    step(1, 1, 1, 1, 3'b111, 3'b101, 3'b111, 64'hff, 1, 1, "R2");
    step(1, 2, 0, 1, 3'b111, 3'b111, 3'b101, 64'h40, 1, 1, "R2");
    step(1, 3, 1, 1, 3'b111, 3'b111, 3'b000, 64'h41, 1, 1, "R2");
    step(1, 0, 0, 0, 3'b111, 3'b000, 3'b110, 64'h7f, 1, 1, "R3");
    step(1, 0, 1, 0, 3'b111, 3'b000, 3'b000, 64'h80, 0, 1, "R3");
    step(1, 1, 0, 1, 3'b000, 3'b000, 3'b000, 64'h3, 1, 1, "R4");
    step(1, 3, 0, 1, 3'b111, 3'b000, 3'b000, 64'h3, 1, 1, "R4");
    step(1, 0, 3, 1, 3'b000, 3'b000, 3'b000, 64'hdead_beef, 0, 1, "R5");
    step(1, 2, 1, 0, 3'b010, 3'b010, 3'b010, 64'h100, 1, 0, "R6");
    step(1, 1, 0, 0, 3'b010, 3'b010, 3'b010, 64'h100, 1, 0, "R6");
    step(1, 3, 0, 0, 3'b010, 3'b010, 3'b010, 64'h100, 1, 0, "R6");
    step(1, 0, 1, 1, 3'b111, 3'b111, 3'b111, 64'hffff_ffff_ffff_ffff, 1, 0, "R8");
    step(1, 0, 1, 0, 3'b111, 3'b111, 3'b111, 64'h3f, 1, 0, "R8");
    step(1, 3, 0, 0, 3'b111, 3'b111, 3'b111, 64'h5, 0, 1, "R9");
    step(1, 2, 0, 1, 3'b111, 3'b111, 3'b111, 64'h5, 0, 0, "R9");
    step(1, 1, 1, 0, 3'b111, 3'b111, 3'b111, 64'h5, 0, 0, "R9");
    step(0, 1, 1, 0, 3'b111, 3'b111, 3'b111, 64'h5, 1, 1, "R11");

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] pr;
      pr = 2'($urandom_range(0, 2));
      if (pr == 2) pr = 3;
      step(1'($urandom), 2'($urandom), pr, 1'($urandom),
           3'($urandom), 3'($urandom), 3'($urandom),
           {32'($urandom), 32'($urandom)}, 1'($urandom), 1'($urandom), "");
    end
    step(0, 0, 3, 0, 3'b111, 3'b111, 3'b111, 64'h0, 1, 1, "R11");
    step(0, 0, 3, 0, 3'b111, 3'b111, 3'b111, 64'h0, 1, 1, "R11");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule